// File: doc/BRIEF.md
# Store Byte-Lane Formatter (Big-Endian)

This block sits between a processor's store path and a word-wide data memory. It takes one store request, made of an access size, a byte address and a 32-bit register value. From that it builds the write that the memory port needs: a 4-bit lane-enable mask, a 32-bit data word with the store bytes moved into their lanes, and the word address. Lanes are numbered big-endian. Byte offset 0 within a word is the most significant lane, enabled by mask bit 3, and offset 3 is the least significant lane, enabled by mask bit 0.

Requests that break the alignment rule are not written. The same holds for requests that carry the reserved size code. For these the block returns an error flag with an all-zero mask and zero data. The result sits in one output register with a valid/ready handshake on both sides. The memory can stall the formatter, and the formatter then stalls the requester.

Top module: `store_lane_fmt`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, wr_valid, wr_mask and wr_err are all 0.
- R2: A word store (size code 2) with address bits 1:0 equal to 0 gives mask 4'b1111 and passes the register value through unchanged.
- R3: A byte store (size code 0) at offset k (address bits 1:0) enables only mask bit 3-k. It places register bits 7:0 in data bits [31-8k -: 8], and all other data bits are 0.
- R4: A halfword store (size code 1) with address bit 1 clear gives mask 4'b1100 and data {value[15:0], 16'h0}. With address bit 1 set it gives mask 4'b0011 and data {16'h0, value[15:0]}.
- R5: A word store with address bits 1:0 not 0, or a halfword store with address bit 0 set, gives wr_err=1, mask 0 and data 0.
- R6: The reserved size code 3 gives wr_err=1, mask 0 and data 0, whatever the address.
- R7: A request is accepted on a rising edge where req_valid and req_ready are both 1. Its result shows on the outputs with wr_valid=1 after that edge. req_ready is 1 whenever the output register is empty or wr_ready is 1. With nothing new accepted, wr_valid drops after an edge where wr_ready is 1.
- R8: While wr_valid=1 and wr_ready=0, req_ready is 0. Mask, data, word address and error then stay unchanged, and any waiting request is ignored until wr_ready rises.
- R9: wr_waddr equals the accepted address with bits 1:0 forced to 0, for legal and error results alike.
- R10: With wr_ready held at 1, a new request is accepted on every cycle and each result replaces the previous one one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Formatter can take a request this cycle |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address of the store |
| req_wdata | input | 32 | Register value, right-justified |
| wr_valid | output | 1 | Formatted write present |
| wr_ready | input | 1 | Memory takes the write this cycle |
| wr_mask | output | 4 | Lane enables, bit 3 = byte offset 0 |
| wr_data | output | 32 | Lane-steered write data |
| wr_waddr | output | ADDR_W | Word-aligned address |
| wr_err | output | 1 | Misaligned or reserved-size request |

## Verification
The bench works through all four byte offsets, both halfword positions and aligned words. A design that numbered the lanes little-endian would light the mirrored mask bit and put the byte at the wrong end of the word. A design that kept stale upper bytes would leave non-zero data in the disabled lanes. Every misaligned word and halfword offset is applied, together with the reserved size code at an aligned address. A checker that only tested address bit 0, or that trusted the size code, would let a write through with a non-zero mask. A stall with a new request waiting shows whether the output register is overwritten or the request is taken too early. A back-to-back run shows whether a bubble is added when the memory never stalls.

// File: rtl/st_fmt_pkg.sv
// Package: shared constants and the store-size encoding for the lane formatter.
// Assumes a 32-bit data word made of 8-bit lanes.
package st_fmt_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int OFF_W  = $clog2(LANES);
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } st_size_e;

endpackage

// File: rtl/st_align_chk.sv
// Module: st_align_chk
// Decides whether a store request may be written: it must use a legal size
// code and be aligned to its own size. Purely combinational.
// Assumes the offset input is the low address bits within one word.
module st_align_chk
    import st_fmt_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic             err
);

    // Flag reserved sizes and offsets that do not fit the access size.
    always_comb begin
        unique case (st_size_e'(size))
            SZ_BYTE: err = 1'b0;
            SZ_HALF: err = off[0];
            SZ_WORD: err = |off;
            default: err = 1'b1;
        endcase
    end

endmodule

// File: rtl/st_lane_steer.sv
// Module: st_lane_steer
// Builds the lane-enable mask and the lane-steered write data for one store,
// with big-endian lane numbering: byte offset o drives mask bit LANES-1-o.
// Disabled lanes carry zero. A set kill input blanks mask and data.
// Assumes the request has already been checked for alignment.
module st_lane_steer
    import st_fmt_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] wdata,
    input  logic              kill,
    output logic [LANES-1:0]  mask,
    output logic [WORD_W-1:0] data
);

    logic is_byte;
    logic is_half;
    logic is_word;

    // Decode the access size once for all lanes.
    always_comb begin
        is_byte = (st_size_e'(size) == SZ_BYTE);
        is_half = (st_size_e'(size) == SZ_HALF);
        is_word = (st_size_e'(size) == SZ_WORD);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_OFS = OFF_W'(LANES - 1 - g);

        logic                   lane_en;
        logic [LANE_W-1:0]      lane_src;

        // Enable this lane when the access covers its byte offset.
        always_comb begin
            lane_en = is_word
                    | (is_half & (LANE_OFS[OFF_W-1] == off[OFF_W-1]))
                    | (is_byte & (LANE_OFS == off));
        end

        // Select which byte of the register value lands in this lane.
        always_comb begin
            if (is_word)
                lane_src = wdata[g*LANE_W +: LANE_W];
            else if (is_half)
                lane_src = LANE_OFS[0] ? wdata[LANE_W-1:0] : wdata[2*LANE_W-1:LANE_W];
            else
                lane_src = wdata[LANE_W-1:0];
        end

        // Drive the lane outputs, zero when disabled or killed.
        always_comb begin
            mask[g]                    = lane_en & ~kill;
            data[g*LANE_W +: LANE_W]   = (lane_en & ~kill) ? lane_src : '0;
        end
    end

endmodule

// File: rtl/st_out_reg.sv
// Module: st_out_reg
// Single output register with a valid/ready handshake. It loads a new result
// when told to, holds it while the sink stalls, and empties once the sink
// takes it with nothing new arriving.
// Assumes load is only raised while ready_up is high.
module st_out_reg
    import st_fmt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sink_ready,
    input  logic [LANES-1:0]  d_mask,
    input  logic [WORD_W-1:0] d_data,
    input  logic [ADDR_W-1:0] d_waddr,
    input  logic              d_err,
    output logic              ready_up,
    output logic              q_valid,
    output logic [LANES-1:0]  q_mask,
    output logic [WORD_W-1:0] q_data,
    output logic [ADDR_W-1:0] q_waddr,
    output logic              q_err
);

    // Accept upstream when the register is empty or being drained.
    always_comb begin
        ready_up = ~q_valid | sink_ready;
    end

    // Track whether the register holds a result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_valid <= 1'b0;
        else if (load)
            q_valid <= 1'b1;
        else if (sink_ready)
            q_valid <= 1'b0;
    end

    // Capture the payload on load, keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_mask  <= '0;
            q_data  <= '0;
            q_waddr <= '0;
            q_err   <= 1'b0;
        end else if (load) begin
            q_mask  <= d_mask;
            q_data  <= d_data;
            q_waddr <= d_waddr;
            q_err   <= d_err;
        end
    end

endmodule

// File: rtl/store_lane_fmt.sv
// Module: store_lane_fmt
// Top of the big-endian store formatter. It turns a size/address/value store
// request into a lane mask, steered data and a word address for a word-wide
// memory, and rejects misaligned or reserved-size requests with an error and
// an empty mask. The result goes out through one handshaked register.
// Assumes a 32-bit data word; the address width is a parameter.
module store_lane_fmt
    import st_fmt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [LANES-1:0]  wr_mask,
    output logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] wr_waddr,
    output logic              wr_err
);

    logic [OFF_W-1:0]  off;
    logic              bad;
    logic [LANES-1:0]  nx_mask;
    logic [WORD_W-1:0] nx_data;
    logic [ADDR_W-1:0] nx_waddr;
    logic              take;

    // Split the address into the in-word offset and the word address.
    always_comb begin
        off      = req_addr[OFF_W-1:0];
        nx_waddr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    // A request is taken when both sides of the input handshake agree.
    always_comb begin
        take = req_valid & req_ready;
    end

    st_align_chk u_chk_align (
        .size (req_size),
        .off  (off),
        .err  (bad)
    );

    st_lane_steer u_steer (
        .size  (req_size),
        .off   (off),
        .wdata (req_wdata),
        .kill  (bad),
        .mask  (nx_mask),
        .data  (nx_data)
    );

    st_out_reg #(.ADDR_W(ADDR_W)) u_oreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take),
        .sink_ready (wr_ready),
        .d_mask     (nx_mask),
        .d_data     (nx_data),
        .d_waddr    (nx_waddr),
        .d_err      (bad),
        .ready_up   (req_ready),
        .q_valid    (wr_valid),
        .q_mask     (wr_mask),
        .q_data     (wr_data),
        .q_waddr    (wr_waddr),
        .q_err      (wr_err)
    );

endmodule

// File: rtl/store_lane_fmt_chk.sv
// Module: store_lane_fmt_chk
// Property checker for store_lane_fmt, attached by the bind below.
module store_lane_fmt_chk
    import st_fmt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [LANES-1:0]  wr_mask,
    input logic [WORD_W-1:0] wr_data,
    input logic [ADDR_W-1:0] wr_waddr,
    input logic              wr_err
);

    // R5 / R6: an error result never enables a lane or carries data.
    p_err_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_err) |-> (wr_mask == '0 && wr_data == '0));

    // R3 / R4 / R2: a legal result enables one lane, an aligned half, or all lanes.
    p_lane_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_err) |->
            ($countones(wr_mask) == 1 || wr_mask == 4'b1100 ||
             wr_mask == 4'b0011 || wr_mask == 4'b1111));

    // R7: an accepted request shows up as a valid result on the next cycle.
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> wr_valid);

    // R8: a stalled result keeps its contents.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=>
            (wr_valid && $stable(wr_mask) && $stable(wr_data) &&
             $stable(wr_waddr) && $stable(wr_err)));

    // R8: no new request is taken while the output is stalled.
    p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> !req_ready);

    // R9: the word address is always word aligned.
    p_waddr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_waddr[OFF_W-1:0] == '0));

endmodule

bind store_lane_fmt store_lane_fmt_chk #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data),
    .wr_waddr  (wr_waddr),
    .wr_err    (wr_err)
);

// File: tb/sim_store_lane_fmt.sv
module sim_store_lane_fmt;

    localparam int AW = 32;
    localparam int NV = 15;
    localparam int VW = 2 + 32 + 32 + 4 + 32 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [3:0]    wr_mask;
    logic [31:0]   wr_data;
    logic [AW-1:0] wr_waddr;
    logic          wr_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    store_lane_fmt #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_mask(wr_mask), .wr_data(wr_data), .wr_waddr(wr_waddr), .wr_err(wr_err)
    );

    // {size, addr, wdata, exp_mask, exp_data, exp_err}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd2, 32'h0000_0100, 32'h1122_3344, 4'hF, 32'h1122_3344, 1'b0}, // R2
        {2'd2, 32'h2000_0004, 32'hDEAD_BEEF, 4'hF, 32'hDEAD_BEEF, 1'b0}, // R2
        {2'd0, 32'h0000_0010, 32'hAABB_CC5A, 4'h8, 32'h5A00_0000, 1'b0}, // R3
        {2'd0, 32'h0000_0011, 32'h0000_00A5, 4'h4, 32'h00A5_0000, 1'b0}, // R3
        {2'd0, 32'h0000_0012, 32'hFFFF_FF3C, 4'h2, 32'h0000_3C00, 1'b0}, // R3
        {2'd0, 32'h0000_0013, 32'h1234_5678, 4'h1, 32'h0000_0078, 1'b0}, // R3
        {2'd1, 32'h0000_0020, 32'h9999_BEEF, 4'hC, 32'hBEEF_0000, 1'b0}, // R4
        {2'd1, 32'h0000_0022, 32'h7777_CAFE, 4'h3, 32'h0000_CAFE, 1'b0}, // R4
        {2'd2, 32'h0000_0031, 32'h0102_0304, 4'h0, 32'h0000_0000, 1'b1}, // R5
        {2'd2, 32'h0000_0032, 32'h0102_0304, 4'h0, 32'h0000_0000, 1'b1}, // R5
        {2'd2, 32'h0000_0033, 32'h0102_0304, 4'h0, 32'h0000_0000, 1'b1}, // R5
        {2'd1, 32'h0000_0041, 32'h0000_ABCD, 4'h0, 32'h0000_0000, 1'b1}, // R5
        {2'd1, 32'h0000_0043, 32'h0000_ABCD, 4'h0, 32'h0000_0000, 1'b1}, // R5
        {2'd3, 32'h0000_0050, 32'hFFFF_FFFF, 4'h0, 32'h0000_0000, 1'b1}, // R6
        {2'd3, 32'h0000_0053, 32'h0000_00FF, 4'h0, 32'h0000_0000, 1'b1}  // R6
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] s, input logic [31:0] a, input logic [31:0] d);
        req_valid = 1'b1;
        req_size  = s;
        req_addr  = a;
        req_wdata = d;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid", 64'(wr_valid), 64'd0);
        chk("R1 mask",  64'(wr_mask),  64'd0);
        chk("R1 err",   64'(wr_err),   64'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 valid after release", 64'(wr_valid), 64'd0);

        // Table walk: one request, check one cycle later (R2..R6, R7, R9)
        wr_ready = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            logic [31:0]   a;
            v = VEC[i];
            a = v[100:69];
            drive(v[102:101], a, v[68:37]);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            chk($sformatf("R7 valid v%0d", i), 64'(wr_valid), 64'd1);
            chk($sformatf("R2-6 mask v%0d", i), 64'(wr_mask), 64'(v[36:33]));
            chk($sformatf("R2-6 data v%0d", i), 64'(wr_data), 64'(v[32:1]));
            chk($sformatf("R5 err v%0d", i), 64'(wr_err), 64'(v[0]));
            chk($sformatf("R9 waddr v%0d", i), 64'(wr_waddr), 64'(a & 32'hFFFF_FFFC));
        end
        @(posedge clk);
        @(negedge clk);
        chk("R7 valid drops when drained", 64'(wr_valid), 64'd0);

        // R8: stall holds the result and blocks the waiting request
        wr_ready = 1'b0;
        drive(2'd2, 32'h0000_0060, 32'hA5A5_A5A5);
        @(posedge clk);
        @(negedge clk);
        drive(2'd0, 32'h0000_0071, 32'h0000_00EE);
        chk("R8 ready low in stall", 64'(req_ready), 64'd0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 held mask", 64'(wr_mask), 64'hF);
        chk("R8 held data", 64'(wr_data), 64'hA5A5_A5A5);
        chk("R8 held waddr", 64'(wr_waddr), 64'h60);
        wr_ready = 1'b1;
        #1;
        chk("R7 ready with sink ready", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 waiting req mask", 64'(wr_mask), 64'h4);
        chk("R8 waiting req data", 64'(wr_data), 64'h00EE_0000);
        chk("R9 waiting req waddr", 64'(wr_waddr), 64'h70);
        @(posedge clk);
        @(negedge clk);
        chk("R7 empty after drain", 64'(wr_valid), 64'd0);

        // R10: back-to-back requests with no stall
        drive(2'd2, 32'h0000_0084, 32'h0BAD_F00D);
        @(posedge clk);
        @(negedge clk);
        chk("R10 first data", 64'(wr_data), 64'h0BAD_F00D);
        drive(2'd1, 32'h0000_0082, 32'h0000_1234);
        @(posedge clk);
        @(negedge clk);
        chk("R10 second valid", 64'(wr_valid), 64'd1);
        chk("R10 second mask", 64'(wr_mask), 64'h3);
        chk("R10 second data", 64'(wr_data), 64'h0000_1234);
        chk("R10 second waddr", 64'(wr_waddr), 64'h80);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule